// File: doc/BRIEF.md
# Instantly-Clearable Keyed Linked-List Hit Store

This block collects hit words during an event and files each one under a coarse key and a layer number. All hits that share a key and a layer form one singly linked chain. The newest hit becomes the chain head, and its next pointer holds the previous head. A clear pulse between events empties every chain in one clock cycle. It does this by moving to a new generation number instead of sweeping memory.

Retrieval runs through several independent channels. A request names a key and a mask of layers. A free channel accepts it and walks the masked layers in ascending order. It emits every hit in each chain, or a single missing word for a layer that holds nothing. The channels share one registered memory read port. A rotating slot hands that port to each channel in turn, so each walk advances one node every NCH cycles. Up to NCH walks proceed at the same time.

Top module: `llist_store`

## Requirements
- R1: After reset, out_valid and overflow are 0, req_ready is 1 and req_chan is 0.
- R2: For a masked layer that holds hits under the requested key, the block emits every stored hit of that chain, newest first, with out_layer set to that layer. out_last is 1 only on the oldest hit.
- R3: The block visits only the layers whose bit is set in req_mask, where bit i selects layer i. It visits them in ascending layer order.
- R4: A masked layer with no hit under the key in the current event yields exactly one word with out_missing=1, out_last=1 and out_hit=0.
- R5: out_end is 1 on the final word of a request and on no other word.
- R6: A clr pulse empties every chain in one cycle, so later requests report each layer as missing. A write presented in the same cycle as clr is dropped. clr returns overflow to 0.
- R7: An event accepts at most DEPTH writes. After that, further writes are dropped and overflow is 1 from the cycle after the first dropped write until the next clr.
- R8: Up to NCH requests are in flight at once. req_chan gives the lowest-numbered free channel, which accepts the request, and each word carries that channel in out_chan. req_ready is 0 while all channels are busy.
- R9: The channels share one read port in rotation, so no channel produces words in two consecutive cycles.
- R10: A request with an all-zero req_mask is ignored. It produces no word and occupies no channel.
- R11: clr aborts all walks in progress. No word appears in the cycle after clr, and no word from an aborted request ever appears.
- R12: Hits from earlier events stay invisible even after the generation counter has wrapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Event clear pulse |
| wr_en | input | 1 | Store a hit this cycle |
| wr_key | input | KEY_W | Coarse key of the hit |
| wr_layer | input | LYR_W | Layer of the hit |
| wr_hit | input | HIT_W | Full-resolution hit word |
| overflow | output | 1 | Capacity exhausted in this event |
| req_valid | input | 1 | Retrieval request present |
| req_key | input | KEY_W | Key to retrieve |
| req_mask | input | LAYERS | Layers to visit, bit i selects layer i |
| req_ready | output | 1 | A channel is free |
| req_chan | output | CH_W | Channel that accepts a request this cycle |
| out_valid | output | 1 | Output word valid |
| out_hit | output | HIT_W | Retrieved hit, zero on a missing word |
| out_layer | output | LYR_W | Layer of the word |
| out_last | output | 1 | Final word of this layer |
| out_missing | output | 1 | Layer had no hits |
| out_end | output | 1 | Final word of the request |
| out_chan | output | CH_W | Channel that produced the word |

## Verification
The bench builds the block with DEPTH=8, GEN_W=2, KEY_W=3, LAYERS=4 and NCH=4.

- The eight-entry store fills after a few writes, which brings the overflow and drop behaviour within reach.
- The two-bit generation counter wraps after three clears, so the bench can show that stale chains stay hidden across a wrap.
- Four channels and four layers let the bench fill every channel with full-mask requests. That exposes interleaved output, the req_ready stall and the lowest-free channel choice.

// File: rtl/llist_pkg.sv
package llist_pkg;
   // Phase of one retrieval channel
   typedef enum logic {
      PH_SEEK = 1'b0,   // choose next masked layer, read its head
      PH_WALK = 1'b1    // follow next pointers inside a chain
   } ch_phase_e;
endpackage

// File: rtl/llist_heads.sv
module llist_heads #(
   parameter int KEY_W = 4,
   parameter int LYR_W = 2,
   parameter int PTR_W = 6,
   parameter int GEN_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [LYR_W-1:0] wr_layer,
   input  logic [KEY_W-1:0] wr_key,
   input  logic [PTR_W-1:0] wr_ptr,
   output logic             wr_old_v,
   output logic [PTR_W-1:0] wr_old_p,
   input  logic [LYR_W-1:0] lk_layer,
   input  logic [KEY_W-1:0] lk_key,
   output logic             lk_v,
   output logic [PTR_W-1:0] lk_p
);
   localparam int IDX_W   = LYR_W + KEY_W;
   localparam int NH      = 1 << IDX_W;
   localparam logic [GEN_W-1:0] GEN_TOP = {GEN_W{1'b1}};

   logic [GEN_W-1:0] gen;
   logic [GEN_W-1:0] hgen [NH];
   logic [PTR_W-1:0] hptr [NH];
   logic [IDX_W-1:0] widx, ridx;

   assign widx = {wr_layer, wr_key};
   assign ridx = {lk_layer, lk_key};

   // generation 0 is never current: heads tagged 0 are always stale
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen <= GEN_W'(1);
         for (int i = 0; i < NH; i++) hgen[i] <= '0;
      end else if (clr) begin
         if (gen == GEN_TOP) begin
            gen <= GEN_W'(1);
            for (int i = 0; i < NH; i++) hgen[i] <= '0;
         end else begin
            gen <= gen + GEN_W'(1);
         end
      end else if (wr_en) begin
         hgen[widx] <= gen;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !clr) hptr[widx] <= wr_ptr;
   end

   assign wr_old_v = (hgen[widx] == gen);
   assign wr_old_p = hptr[widx];
   assign lk_v     = (hgen[ridx] == gen);
   assign lk_p     = hptr[ridx];
endmodule

// File: rtl/llist_mem.sv
module llist_mem #(
   parameter int DEPTH = 64,
   parameter int PTR_W = 6,
   parameter int HIT_W = 16
) (
   input  logic             clk,
   input  logic             we,
   input  logic [PTR_W-1:0] waddr,
   input  logic [HIT_W-1:0] whit,
   input  logic             wnv,
   input  logic [PTR_W-1:0] wnp,
   input  logic [PTR_W-1:0] raddr,
   output logic [HIT_W-1:0] rhit,
   output logic             rnv,
   output logic [PTR_W-1:0] rnp
);
   logic [HIT_W-1:0] hit_q  [DEPTH];
   logic [PTR_W:0]   link_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         hit_q[waddr]  <= whit;
         link_q[waddr] <= {wnv, wnp};
      end
      rhit         <= hit_q[raddr];
      {rnv, rnp}   <= link_q[raddr];
   end
endmodule

// File: rtl/llist_sched.sv
module llist_sched
   import llist_pkg::*;
#(
   parameter int KEY_W  = 4,
   parameter int LAYERS = 4,
   parameter int LYR_W  = 2,
   parameter int PTR_W  = 6,
   parameter int HIT_W  = 16,
   parameter int NCH    = 4,
   parameter int CH_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              req_valid,
   input  logic [KEY_W-1:0]  req_key,
   input  logic [LAYERS-1:0] req_mask,
   output logic              req_ready,
   output logic [CH_W-1:0]   req_chan,
   output logic [LYR_W-1:0]  lk_layer,
   output logic [KEY_W-1:0]  lk_key,
   input  logic              lk_v,
   input  logic [PTR_W-1:0]  lk_p,
   output logic [PTR_W-1:0]  rd_addr,
   input  logic [HIT_W-1:0]  rd_hit,
   input  logic              rd_nv,
   input  logic [PTR_W-1:0]  rd_np,
   output logic              out_valid,
   output logic [HIT_W-1:0]  out_hit,
   output logic [LYR_W-1:0]  out_layer,
   output logic              out_last,
   output logic              out_missing,
   output logic              out_end,
   output logic [CH_W-1:0]   out_chan
);
   logic [CH_W-1:0]   slot;
   logic [NCH-1:0]    busy;
   logic [KEY_W-1:0]  ch_key [NCH];
   logic [LAYERS-1:0] pend   [NCH];
   ch_phase_e         phase  [NCH];
   logic [PTR_W-1:0]  ptr    [NCH];
   logic [LYR_W-1:0]  lay    [NCH];

   logic              s1_valid, s1_miss;
   logic [CH_W-1:0]   s1_chan;
   logic [LYR_W-1:0]  s1_layer;

   logic [LYR_W-1:0]  seek_l, iss_layer;
   logic              walking, fire, accept, iss_miss, w_last, w_end;

   always_comb begin
      req_chan = '0;
      for (int c = NCH - 1; c >= 0; c--) if (!busy[c]) req_chan = CH_W'(c);
   end
   assign req_ready = ~&busy;
   assign accept    = req_valid && req_ready && (|req_mask) && !clr;

   always_comb begin
      seek_l = '0;
      for (int l = LAYERS - 1; l >= 0; l--) if (pend[slot][l]) seek_l = LYR_W'(l);
   end

   assign walking   = (phase[slot] == PH_WALK);
   assign fire      = busy[slot] && !clr;
   assign lk_layer  = seek_l;
   assign lk_key    = ch_key[slot];
   assign iss_layer = walking ? lay[slot] : seek_l;
   assign iss_miss  = !walking && !lk_v;
   assign rd_addr   = walking ? ptr[slot] : lk_p;

   assign w_last    = s1_miss || !rd_nv;
   assign w_end     = w_last && (pend[s1_chan] == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot     <= '0;
         busy     <= '0;
         s1_valid <= 1'b0;
         s1_miss  <= 1'b0;
         s1_chan  <= '0;
         s1_layer <= '0;
         for (int c = 0; c < NCH; c++) begin
            ch_key[c] <= '0;
            pend[c]   <= '0;
            phase[c]  <= PH_SEEK;
            ptr[c]    <= '0;
            lay[c]    <= '0;
         end
      end else begin
         slot <= (slot == CH_W'(NCH - 1)) ? '0 : slot + CH_W'(1);
         if (clr) begin
            busy     <= '0;
            s1_valid <= 1'b0;
            for (int c = 0; c < NCH; c++) phase[c] <= PH_SEEK;
         end else begin
            s1_valid <= fire;
            if (fire) begin
               s1_chan  <= slot;
               s1_layer <= iss_layer;
               s1_miss  <= iss_miss;
               if (!walking) begin
                  pend[slot][seek_l] <= 1'b0;
                  lay[slot]          <= seek_l;
               end
            end
            if (s1_valid) begin
               if (w_last) begin
                  phase[s1_chan] <= PH_SEEK;
                  if (w_end) busy[s1_chan] <= 1'b0;
               end else begin
                  phase[s1_chan] <= PH_WALK;
                  ptr[s1_chan]   <= rd_np;
               end
            end
            if (accept) begin
               busy[req_chan]   <= 1'b1;
               ch_key[req_chan] <= req_key;
               pend[req_chan]   <= req_mask;
               phase[req_chan]  <= PH_SEEK;
            end
         end
      end
   end

   assign out_valid   = s1_valid;
   assign out_hit     = s1_miss ? '0 : rd_hit;
   assign out_layer   = s1_layer;
   assign out_last    = w_last;
   assign out_missing = s1_miss;
   assign out_end     = w_end;
   assign out_chan    = s1_chan;
endmodule

// File: rtl/llist_store.sv
module llist_store #(
   parameter  int HIT_W  = 16,
   parameter  int KEY_W  = 4,
   parameter  int LAYERS = 4,
   parameter  int DEPTH  = 64,
   parameter  int GEN_W  = 4,
   parameter  int NCH    = 4,
   localparam int LYR_W  = (LAYERS > 1) ? $clog2(LAYERS) : 1,
   localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [KEY_W-1:0]  wr_key,
   input  logic [LYR_W-1:0]  wr_layer,
   input  logic [HIT_W-1:0]  wr_hit,
   output logic              overflow,
   input  logic              req_valid,
   input  logic [KEY_W-1:0]  req_key,
   input  logic [LAYERS-1:0] req_mask,
   output logic              req_ready,
   output logic [CH_W-1:0]   req_chan,
   output logic              out_valid,
   output logic [HIT_W-1:0]  out_hit,
   output logic [LYR_W-1:0]  out_layer,
   output logic              out_last,
   output logic              out_missing,
   output logic              out_end,
   output logic [CH_W-1:0]   out_chan
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2)  begin : g_bad_depth  $error("DEPTH must be at least 2");  end
   if (NCH < 2)    begin : g_bad_nch    $error("NCH must be at least 2");    end
   if (GEN_W < 2)  begin : g_bad_gen    $error("GEN_W must be at least 2");  end
   if (LAYERS < 2) begin : g_bad_layers $error("LAYERS must be at least 2"); end

   logic [CNT_W-1:0] wp;
   logic             full, wr_acc;
   logic             old_v, lk_v, rd_nv;
   logic [PTR_W-1:0] old_p, lk_p, rd_addr, rd_np;
   logic [LYR_W-1:0] lk_layer;
   logic [KEY_W-1:0] lk_key;
   logic [HIT_W-1:0] rd_hit;

   assign full   = (wp == CNT_W'(DEPTH));
   assign wr_acc = wr_en && !clr && !full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp       <= '0;
         overflow <= 1'b0;
      end else if (clr) begin
         wp       <= '0;
         overflow <= 1'b0;
      end else if (wr_en) begin
         if (full) overflow <= 1'b1;
         else      wp       <= wp + CNT_W'(1);
      end
   end

   llist_heads #(.KEY_W(KEY_W), .LYR_W(LYR_W), .PTR_W(PTR_W), .GEN_W(GEN_W)) u_heads (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .wr_en(wr_acc), .wr_layer(wr_layer), .wr_key(wr_key), .wr_ptr(wp[PTR_W-1:0]),
      .wr_old_v(old_v), .wr_old_p(old_p),
      .lk_layer(lk_layer), .lk_key(lk_key), .lk_v(lk_v), .lk_p(lk_p)
   );

   llist_mem #(.DEPTH(DEPTH), .PTR_W(PTR_W), .HIT_W(HIT_W)) u_mem (
      .clk(clk), .we(wr_acc), .waddr(wp[PTR_W-1:0]), .whit(wr_hit),
      .wnv(old_v), .wnp(old_p),
      .raddr(rd_addr), .rhit(rd_hit), .rnv(rd_nv), .rnp(rd_np)
   );

   llist_sched #(.KEY_W(KEY_W), .LAYERS(LAYERS), .LYR_W(LYR_W), .PTR_W(PTR_W),
                 .HIT_W(HIT_W), .NCH(NCH), .CH_W(CH_W)) u_sched (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .req_valid(req_valid), .req_key(req_key), .req_mask(req_mask),
      .req_ready(req_ready), .req_chan(req_chan),
      .lk_layer(lk_layer), .lk_key(lk_key), .lk_v(lk_v), .lk_p(lk_p),
      .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_nv(rd_nv), .rd_np(rd_np),
      .out_valid(out_valid), .out_hit(out_hit), .out_layer(out_layer),
      .out_last(out_last), .out_missing(out_missing), .out_end(out_end),
      .out_chan(out_chan)
   );
endmodule

// File: rtl/llist_store_chk.sv
module llist_store_chk #(
   parameter int HIT_W = 16,
   parameter int CH_W  = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic             overflow,
   input logic             out_valid,
   input logic [HIT_W-1:0] out_hit,
   input logic             out_last,
   input logic             out_missing,
   input logic             out_end,
   input logic [CH_W-1:0]  out_chan
);
   // R4
   missing_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_missing |-> out_last && (out_hit == '0));
   // R5
   end_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_end |-> out_last);
   // R7
   overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow && !clr |=> overflow);
   // R6
   clear_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !overflow);
   // R11
   clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !out_valid);
   // R9
   chan_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !(out_valid && out_chan == $past(out_chan)));
endmodule

bind llist_store llist_store_chk #(.HIT_W(HIT_W), .CH_W(CH_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr(clr), .overflow(overflow),
   .out_valid(out_valid), .out_hit(out_hit), .out_last(out_last),
   .out_missing(out_missing), .out_end(out_end), .out_chan(out_chan)
);

// File: tb/tb_llist_store.sv
module tb_llist_store;
   localparam int HIT_W = 16, KEY_W = 3, LAYERS = 4, DEPTH = 8, GEN_W = 2, NCH = 4;
   localparam int LYR_W = 2, CH_W = 2, NK = 1 << KEY_W;

   logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, wr_en = 1'b0, req_valid = 1'b0;
   logic [KEY_W-1:0] wr_key = '0, req_key = '0;
   logic [LYR_W-1:0] wr_layer = '0;
   logic [HIT_W-1:0] wr_hit = '0;
   logic [LAYERS-1:0] req_mask = '0;
   logic overflow, req_ready, out_valid, out_last, out_missing, out_end;
   logic [CH_W-1:0] req_chan, out_chan;
   logic [HIT_W-1:0] out_hit;
   logic [LYR_W-1:0] out_layer;

   always #5 clk = ~clk;

   llist_store #(.HIT_W(HIT_W), .KEY_W(KEY_W), .LAYERS(LAYERS), .DEPTH(DEPTH),
                 .GEN_W(GEN_W), .NCH(NCH)) dut (.*);

   int checks = 0, errors = 0, outstanding = 0, seen = 0, wcount = 0;
   bit exp_ovf = 0;
   int mdl [LAYERS*NK][$];
   logic [20:0] expq [NCH][$];   // {end, missing, last, layer[1:0], hit[15:0]}

   // stimulus table: {key[2:0], layer[1:0], hit[15:0]}
   localparam int NV = 6;
   localparam logic [20:0] WR_TAB [NV] = '{
      {3'd2, 2'd0, 16'hA001}, {3'd2, 2'd0, 16'hA002}, {3'd2, 2'd2, 16'hB001},
      {3'd5, 2'd1, 16'hC001}, {3'd2, 2'd0, 16'hA003}, {3'd5, 2'd3, 16'hD001}};

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         logic [20:0] got, want;
         seen++;
         got = {out_end, out_missing, out_last, out_layer, out_hit};
         if (expq[out_chan].size() == 0) begin
            chk(0, "R11", "unexpected word", got, 0);
         end else begin
            want = expq[out_chan].pop_front();
            // R2 R3 R4 R5 R8: word content and channel routing
            chk(got == want, "R2/R3/R4/R5", "word", got, want);
            if (want[20]) outstanding--;
         end
      end
   end

   task automatic do_write(input int key, input int layer, input int hit, input bit with_clr);
      wr_en = 1; wr_key = KEY_W'(key); wr_layer = LYR_W'(layer); wr_hit = HIT_W'(hit);
      clr = with_clr;
      if (with_clr) model_clear();
      else if (wcount < DEPTH) begin mdl[layer*NK+key].push_front(hit); wcount++; end
      else exp_ovf = 1;
      @(negedge clk);
      wr_en = 0; clr = 0;
   endtask

   function automatic void model_clear();
      for (int i = 0; i < LAYERS*NK; i++) mdl[i].delete();
      wcount = 0; exp_ovf = 0;
   endfunction

   task automatic do_clear();
      clr = 1;
      model_clear();
      @(posedge clk);
      #1;
      for (int c = 0; c < NCH; c++) expq[c].delete();
      outstanding = 0;
      @(negedge clk);
      clr = 0;
   endtask

   task automatic issue(input int key, input int mask, output int ch);
      int cnt;
      while (!req_ready) @(negedge clk);
      req_valid = 1; req_key = KEY_W'(key); req_mask = LAYERS'(mask);
      ch = int'(req_chan);
      cnt = 0;
      for (int l = 0; l < LAYERS; l++) begin
         if (mask[l]) begin
            int n = mdl[l*NK+key].size();
            if (n == 0) begin expq[ch].push_back({1'b0, 1'b1, 1'b1, LYR_W'(l), 16'h0}); cnt++; end
            for (int i = 0; i < n; i++) begin
               expq[ch].push_back({1'b0, 1'b0, (i == n-1), LYR_W'(l), HIT_W'(mdl[l*NK+key][i])});
               cnt++;
            end
         end
      end
      if (cnt > 0) begin
         logic [20:0] t = expq[ch].pop_back();
         t[20] = 1'b1;
         expq[ch].push_back(t);
         outstanding++;
      end
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic wait_idle();
      int guard = 0;
      while (outstanding > 0 && guard < 500) begin @(negedge clk); guard++; end
      chk(outstanding == 0, "R8", "requests drained", outstanding, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R8 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int ch, c0, c1, c2, c3, s0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(out_valid == 0, "R1", "out_valid", out_valid, 0);
      chk(overflow == 0, "R1", "overflow", overflow, 0);
      chk(req_ready == 1, "R1", "req_ready", req_ready, 1);
      chk(req_chan == 0, "R1", "req_chan", req_chan, 0);

      // table walk: fill chains
      for (int i = 0; i < NV; i++)
         do_write(int'(WR_TAB[i][20:18]), int'(WR_TAB[i][17:16]), int'(WR_TAB[i][15:0]), 0);

      // R2 R4 R5: full mask, chains and missing layers
      issue(2, 4'b1111, ch); wait_idle();
      // R3: sparse mask visits only layers 0 and 2
      issue(2, 4'b0101, ch); wait_idle();
      issue(5, 4'b1010, ch); wait_idle();

      // R8: four concurrent requests, lowest free channel each time
      issue(2, 4'b1111, c0); issue(5, 4'b1111, c1); issue(5, 4'b1011, c2); issue(7, 4'b1111, c3);
      chk(c0 == 0 && c1 == 1 && c2 == 2 && c3 == 3, "R8", "channel order",
          c0*1000 + c1*100 + c2*10 + c3, 123);
      chk(req_ready == 0, "R8", "req_ready when full", req_ready, 0);
      wait_idle();

      // R10: empty mask ignored
      req_valid = 1; req_key = 3'd2; req_mask = '0;
      @(negedge clk);
      req_valid = 0;
      s0 = seen;
      repeat (12) @(negedge clk);
      chk(seen == s0, "R10", "words after empty mask", seen - s0, 0);
      chk(req_ready == 1, "R10", "req_ready", req_ready, 1);
      issue(5, 4'b0010, ch);
      chk(ch == 0, "R10", "channel still free", ch, 0);
      wait_idle();

      // R7: capacity and drop
      do_write(3, 1, 16'hE001, 0);
      do_write(3, 1, 16'hE002, 0);
      chk(overflow == 0, "R7", "overflow at capacity", overflow, 0);
      do_write(3, 1, 16'hE003, 0);
      chk(overflow == 1, "R7", "overflow after drop", overflow, 1);
      do_write(4, 0, 16'hF001, 0);
      chk(overflow == 1, "R7", "overflow held", overflow, 1);
      issue(3, 4'b0010, ch); wait_idle();
      issue(4, 4'b0001, ch); wait_idle();

      // R6: clear with simultaneous write
      do_write(6, 2, 16'h6666, 1);
      chk(overflow == 0, "R6", "overflow after clear", overflow, 0);
      issue(6, 4'b0100, ch); wait_idle();
      issue(2, 4'b1111, ch); wait_idle();

      // R11: clear aborts walks in flight
      do_write(1, 0, 16'h1101, 0); do_write(1, 0, 16'h1102, 0); do_write(1, 0, 16'h1103, 0);
      issue(1, 4'b1111, ch);
      @(negedge clk);
      do_clear();
      s0 = seen;
      repeat (20) @(negedge clk);
      chk(seen == s0, "R11", "words after abort", seen - s0, 0);

      // R12: generation wrap keeps old chains hidden
      do_write(1, 1, 16'h7777, 0);
      issue(1, 4'b0010, ch); wait_idle();
      do_clear(); do_clear(); do_clear();
      issue(1, 4'b0010, ch); wait_idle();
      do_clear();
      issue(1, 4'b0011, ch); wait_idle();
      chk(checks > 30, "R12", "word checks made", checks, 31);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule